// File: doc/BRIEF.md
# Two-Channel Serial DAC Word Transmitter

This block is the host side of a serial link to a converter that has two output channels and one shared clock and data line. A client hands over a 16-bit word and a channel number through a ready/valid handshake. The block then builds the serial clock, drives the data line, and pulls low the frame line of the chosen channel only. The word leaves as two bytes, and the frame stays low across the pause between them. The top byte goes first, so on narrow converters the unused high bits arrive first and bit 0 of the word arrives last.

The bytes pass through a shifter whose direction is set per transfer. In the least-significant-first setting the controller mirrors each byte before loading it, so the wire order never changes. When the frame ends, an optional active-low load strobe lets the receiver update its output in step with the end of the transfer. The serial clock period and the pause between bytes are set by parameters.

Top module: `dual_dac_tx`

## Requirements
- R1: With req_chan=0 only fs_a_n goes low for the transfer. With req_chan=1 only fs_b_n goes low. The two frame lines are never low together.
- R2: sclk rests low outside a transfer. sdata holds its value for as long as sclk is high, so it is stable at every falling edge.
- R3: A transfer gives exactly 16 falling edges of sclk, eight for each byte. The selected frame line stays low at every one of them and across the pause between the bytes.
- R4: The wire carries req_word bit 15 at the first falling edge and bit 0 at the sixteenth. The high byte is sent before the low byte.
- R5: When cfg_lsb_first=1 at acceptance, each byte is bit-mirrored before it enters the least-significant-first shifter. The bits on the wire are then the same as in R4.
- R6: The selected frame line returns high SCLK_DIV/2 clock cycles after the sixteenth falling edge.
- R7: If cfg_ldac_en=1 at acceptance, ldac_n goes low for SCLK_DIV clock cycles, starting on the edge that raises the frame line. If cfg_ldac_en=0, ldac_n stays high. The strobe is never low while a frame line is low.
- R8: req_ready is high only when the block is idle, and busy is its inverse. A request is taken on req_valid and req_ready together. Requests made while busy are ignored. busy stays high until the frame line is high again and any strobe has finished.
- R9: Inside a byte, sclk is high for SCLK_DIV/2 cycles and low for SCLK_DIV/2 cycles. The first rising edge comes SCLK_DIV/2 cycles after the frame line falls.
- R10: Between the eighth falling edge and the ninth rising edge, sclk stays low for SCLK_DIV/2 + GAP_CYCLES cycles.
- R11: After reset, both frame lines and ldac_n are high, sclk is low, req_ready is high and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | 1 | Target channel: 0 = A, 1 = B |
| req_word | input | 16 | Word to transmit |
| cfg_lsb_first | input | 1 | Byte shifter emits least significant bit first |
| cfg_ldac_en | input | 1 | Issue the load strobe after the frame |
| busy | output | 1 | Transfer or strobe in progress |
| sclk | output | 1 | Serial clock, rests low |
| sdata | output | 1 | Serial data, valid at sclk falling edge |
| fs_a_n | output | 1 | Active-low frame for channel A |
| fs_b_n | output | 1 | Active-low frame for channel B |
| ldac_n | output | 1 | Active-low load strobe |

## Verification
The assertions check the cycle-level rules on every cycle. They confirm that only one frame line is low, that sclk toggles only inside a frame, that data holds while sclk is high, that the strobe and ready never overlap a frame, and that busy covers the whole frame. The bench scenarios are the only place where the bit order on the wire is compared with the requested word in both shifter modes. They also count the falling edges and measure the clock phase lengths, the pause between the bytes, the frame tail and the length of the strobe. They show as well that a request made during a transfer leaves no trace.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_STROBE
    } tx_state_e;

    function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/dac_byte_shifter.sv
module dac_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         lsb_mode,
    input  logic [W-1:0] din,
    output logic         dout
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = din;
        end else if (shift) begin
            sh_d = lsb_mode ? {1'b0, sh_q[W-1:1]} : {sh_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = lsb_mode ? sh_q[0] : sh_q[W-1];

    // R5: loading and shifting are never requested in the same cycle
    a_r5_load_xor_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/dac_frame_steer.sv
module dac_frame_steer #(
    parameter int NCH  = 2,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            frame_on,
    input  logic [CH_W-1:0] sel,
    output logic [NCH-1:0]  fs_n
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign fs_n[i] = !(frame_on && (sel == CH_W'(i)));
    end
endmodule

// File: rtl/dual_dac_tx.sv
module dual_dac_tx
    import dac_host_pkg::*;
#(
    parameter int SCLK_DIV   = 4,
    parameter int GAP_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_chan,
    input  logic [WORD_W-1:0] req_word,
    input  logic              cfg_lsb_first,
    input  logic              cfg_ldac_en,
    output logic              busy,
    output logic              sclk,
    output logic              sdata,
    output logic              fs_a_n,
    output logic              fs_b_n,
    output logic              ldac_n
);
    localparam int HALF    = SCLK_DIV / 2;
    localparam int CNT_MAX = (2 * HALF > GAP_CYCLES) ? 2 * HALF : GAP_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = $clog2(BYTE_W);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bit_idx;
        logic              second;
        logic              chan;
        logic              lsb;
        logic              ldac_en;
        logic [BYTE_W-1:0] lo_byte;
        logic              sclk;
        logic              frame;
        logic              ldac_n;
    } regs_t;

    regs_t             d, q;
    logic              sh_load, sh_shift, sh_bit;
    logic [BYTE_W-1:0] sh_byte;
    logic [1:0]        fs_vec;

    always_comb begin
        d        = q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_byte  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st      = ST_LEAD;
                    d.cnt     = CNT_W'(HALF - 1);
                    d.bit_idx = '0;
                    d.second  = 1'b0;
                    d.chan    = req_chan;
                    d.lsb     = cfg_lsb_first;
                    d.ldac_en = cfg_ldac_en;
                    d.lo_byte = req_word[BYTE_W-1:0];
                    d.frame   = 1'b1;
                    sh_load   = 1'b1;
                    sh_byte   = cfg_lsb_first ? mirror_byte(req_word[WORD_W-1:BYTE_W])
                                              : req_word[WORD_W-1:BYTE_W];
                end
            end
            ST_LEAD, ST_GAP: begin
                if (q.cnt == '0) begin
                    d.st   = ST_HIGH;
                    d.sclk = 1'b1;
                    d.cnt  = CNT_W'(HALF - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_HIGH: begin
                if (q.cnt == '0) begin
                    d.st   = ST_LOW;
                    d.sclk = 1'b0;
                    d.cnt  = CNT_W'(HALF - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.bit_idx != BIT_W'(BYTE_W - 1)) begin
                    d.bit_idx = q.bit_idx + 1'b1;
                    sh_shift  = 1'b1;
                    d.st      = ST_HIGH;
                    d.sclk    = 1'b1;
                    d.cnt     = CNT_W'(HALF - 1);
                end else if (!q.second) begin
                    d.second  = 1'b1;
                    d.bit_idx = '0;
                    sh_load   = 1'b1;
                    sh_byte   = q.lsb ? mirror_byte(q.lo_byte) : q.lo_byte;
                    d.st      = ST_GAP;
                    d.cnt     = CNT_W'(GAP_CYCLES - 1);
                end else begin
                    d.frame = 1'b0;
                    if (q.ldac_en) begin
                        d.st     = ST_STROBE;
                        d.ldac_n = 1'b0;
                        d.cnt    = CNT_W'(2 * HALF - 1);
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_STROBE: begin
                if (q.cnt == '0) begin
                    d.st     = ST_IDLE;
                    d.ldac_n = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.ldac_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    dac_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .lsb_mode (q.lsb),
        .din      (sh_byte),
        .dout     (sh_bit)
    );

    dac_frame_steer #(.NCH(2), .CH_W(1)) u_steer (
        .frame_on (q.frame),
        .sel      (q.chan),
        .fs_n     (fs_vec)
    );

    assign fs_a_n    = fs_vec[0];
    assign fs_b_n    = fs_vec[1];
    assign sclk      = q.sclk;
    assign sdata     = q.frame & sh_bit;
    assign ldac_n    = q.ldac_n;
    assign req_ready = (q.st == ST_IDLE);
    assign busy      = !req_ready;

    a_r1_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fs_a_n && !fs_b_n));
    a_r2_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (!fs_a_n || !fs_b_n));
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));
    a_r3_frame_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> (!fs_a_n || !fs_b_n));
    a_r7_strobe_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |-> (fs_a_n && fs_b_n));
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fs_a_n && fs_b_n && ldac_n && !sclk));
    a_r8_busy_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_a_n || !fs_b_n) |-> busy);
endmodule

// File: tb/dual_dac_tx_tb.sv
`timescale 1ns/1ps
module dual_dac_tx_tb;
    localparam int DIV  = 4;
    localparam int GAP  = 6;
    localparam int HALF = DIV / 2;

    logic        clk, rst_n;
    logic        req_valid, req_ready, req_chan, cfg_lsb_first, cfg_ldac_en;
    logic [15:0] req_word;
    logic        busy, sclk, sdata, fs_a_n, fs_b_n, ldac_n;

    dual_dac_tx #(.SCLK_DIV(DIV), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_word(req_word), .cfg_lsb_first(cfg_lsb_first),
        .cfg_ldac_en(cfg_ldac_en), .busy(busy), .sclk(sclk), .sdata(sdata),
        .fs_a_n(fs_a_n), .fs_b_n(fs_b_n), .ldac_n(ldac_n)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus monitor, sampled on the falling clock edge
    logic        mon_clr = 0, mon_chan = 0;
    logic        prev_sclk = 0;
    int          nfall, nrise, hi_run, lo_run, first_hi, mid_lo, gap_lo, tail, ldac_cnt;
    logic [15:0] cap;
    bit          sel_bad, oth_low, overlap;

    always @(negedge clk) begin
        logic sel_fs, oth_fs;
        if (mon_clr) begin
            nfall = 0; nrise = 0; hi_run = 0; lo_run = 0; first_hi = 0; mid_lo = 0;
            gap_lo = 0; tail = 0; ldac_cnt = 0; cap = '0;
            sel_bad = 0; oth_low = 0; overlap = 0;
        end else begin
            sel_fs = mon_chan ? fs_b_n : fs_a_n;
            oth_fs = mon_chan ? fs_a_n : fs_b_n;
            if (!oth_fs) oth_low = 1;
            if (prev_sclk && !sclk) begin
                nfall++;
                cap = {cap[14:0], sdata};
                if (sel_fs) sel_bad = 1;
                if (nfall == 1) first_hi = hi_run;
            end
            if (!prev_sclk && sclk) begin
                nrise++;
                if (nrise == 2) mid_lo = lo_run;
                if (nrise == 9) gap_lo = lo_run;
            end
            if (sclk) hi_run = prev_sclk ? hi_run + 1 : 1;
            else      lo_run = !prev_sclk ? lo_run + 1 : 1;
            if (nfall == 16 && !sel_fs) tail++;
            if (!ldac_n) ldac_cnt++;
            if (!ldac_n && (!fs_a_n || !fs_b_n)) overlap = 1;
        end
        prev_sclk = sclk;
    end

    task automatic clear_mon(input logic ch);
        @(posedge clk); #1;
        mon_chan = ch; mon_clr = 1;
        @(negedge clk); #1;
        mon_clr = 0;
    endtask

    task automatic launch(input logic ch, input logic lsb, input logic en, input logic [15:0] w);
        clear_mon(ch);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_chan = ch; cfg_lsb_first = lsb; cfg_ldac_en = en; req_word = w;
        @(negedge clk);
        req_valid = 0; req_chan = ~ch; cfg_lsb_first = ~lsb; cfg_ldac_en = ~en; req_word = ~w;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_xfer(input logic ch, input logic lsb, input logic en, input logic [15:0] w);
        chk(cap == w, lsb ? "R5 wire bits (lsb-first shifter)" : "R4 wire bits", cap, w);
        chk(nfall == 16, "R3 falling edge count", nfall, 16);
        chk(!sel_bad, "R3 selected frame low at every fall", sel_bad, 0);
        chk(!oth_low, ch ? "R1 fs_a_n stays high" : "R1 fs_b_n stays high", oth_low, 0);
        chk(first_hi == HALF && mid_lo == HALF, "R9 clock phase lengths",
            first_hi * 256 + mid_lo, HALF * 256 + HALF);
        chk(gap_lo == HALF + GAP, "R10 inter-byte low time", gap_lo, HALF + GAP);
        chk(tail == HALF, "R6 frame tail after last fall", tail, HALF);
        chk(ldac_cnt == (en ? 2 * HALF : 0), "R7 strobe length", ldac_cnt, en ? 2 * HALF : 0);
        chk(!overlap, "R7 strobe outside frame", overlap, 0);
        chk(fs_a_n && fs_b_n && !busy, "R8 idle after transfer", {fs_a_n, fs_b_n, busy}, 3'b110);
    endtask

    // [18]=chan [17]=lsb-first [16]=strobe enable [15:0]=word
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 16'hA5C3},
        {1'b1, 1'b0, 1'b0, 16'h0FF0},
        {1'b0, 1'b1, 1'b1, 16'h8001},
        {1'b1, 1'b1, 1'b1, 16'h1234},
        {1'b0, 1'b1, 1'b0, 16'hFFFF},
        {1'b1, 1'b0, 1'b1, 16'h0000}
    };

    initial begin
        #500000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_chan = 0; req_word = '0;
        cfg_lsb_first = 0; cfg_ldac_en = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(fs_a_n && fs_b_n && ldac_n && !sclk, "R11 reset line levels",
            {fs_a_n, fs_b_n, ldac_n, sclk}, 4'b1110);
        chk(req_ready && !busy, "R11 reset handshake", {req_ready, busy}, 2'b10);

        for (int i = 0; i < 6; i++) begin
            launch(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);
            wait_idle();
            check_xfer(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);
        end

        // R8: request during a transfer is ignored
        launch(1'b0, 1'b0, 1'b0, 16'h5AA5);
        repeat (10) @(negedge clk);
        chk(!req_ready && busy, "R8 not ready mid-transfer", {req_ready, busy}, 2'b01);
        req_valid = 1; req_chan = 1; req_word = 16'hC33C;
        repeat (3) @(negedge clk);
        req_valid = 0;
        wait_idle();
        chk(cap == 16'h5AA5, "R8 busy request left stream intact", cap, 16'h5AA5);
        chk(!oth_low, "R8 busy request framed no channel B", oth_low, 0);
        repeat (30) @(negedge clk);
        chk(nfall == 16 && !busy, "R8 no second transfer started", nfall, 16);

        // R2: data stays put while sclk is high, checked through one transfer
        launch(1'b1, 1'b1, 1'b0, 16'h6B2D);
        begin
            bit moved = 0;
            logic last = 0;
            @(negedge clk);
            while (busy) begin
                if (sclk && prev_sclk && sdata !== last) moved = 1;
                last = sdata;
                @(negedge clk);
            end
            chk(!moved, "R2 data stable while sclk high", moved, 0);
            chk(!sclk, "R2 sclk rests low", sclk, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule